// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and moves data between them in either direction. Each direction owns a storage register, a capture clock, an output enable and a source select. For each direction, the select decides whether the opposite bus is driven with the live input bus or with the contents of that direction's register. The register of each direction captures its source bus on its own clock edge, whatever the enable and select inputs are doing at the time.

Each bus appears on the ports as three separate vectors: an input, an output and an output enable. This keeps the logic free of tri-states. A pad wrapper outside the block can merge them into bidirectional pins. The two enables have opposite polarity. A-to-B drive is enabled by a high level and B-to-A drive by a low level. Tying both to their inactive levels isolates the buses, and the registers still capture data.

When a bus is being driven by the block, the wrapper feeds the driven value back on that bus's input. This lets a single clock pair load one bus value into both registers. It also lets two live directions reinforce each other and hold the last value on both buses.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both storage registers are zero. The reset acts at once, with no clock edge.
- R2: A rising edge of `a2b_clk` loads `a_in` into the A-side register. This happens for every combination of select and enable inputs.
- R3: A rising edge of `b2a_clk` loads `b_in` into the B-side register. This happens for every combination of select and enable inputs.
- R4: `b_oe` equals `a2b_drive_en` (active high). `a_oe` equals the inverse of `b2a_drive_n` (active low). Both follow their inputs combinationally.
- R5: Whenever an output enable is low, the matching output vector (`a_out` or `b_out`) is all zeros.
- R6: With `b_oe` high, `a2b_use_reg` = 0 puts the live `a_in` on `b_out`, and `a2b_use_reg` = 1 puts the A-side register on `b_out`. Changing the select swaps the source directly.
- R7: With `a_oe` high, `b2a_use_reg` = 0 puts the live `b_in` on `a_out`, and `b2a_use_reg` = 1 puts the B-side register on `a_out`.
- R8: With `a2b_drive_en` = 0 and `b2a_drive_n` = 1, neither bus is driven, and edges on both clocks still store both buses.
- R9: With both directions enabled and both selects 0, `a_out` mirrors `b_in` and `b_out` mirrors `a_in`. When each input carries the other's output, the value held on both buses stays unchanged.
- R10: When only one direction is enabled and live, and the driven bus feeds its driven value back as input, one edge on both clocks loads the driving bus's value into both registers.
- R11: With both directions enabled and both selects 1, the A-side register appears on `b_out` and the B-side register appears on `a_out` at the same time. Both stay unaffected by changes on `a_in` and `b_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| a2b_clk | input | 1 | Capture clock of the A-side register |
| b2a_clk | input | 1 | Capture clock of the B-side register |
| a2b_drive_en | input | 1 | Drive bus B, active high |
| b2a_drive_n | input | 1 | Drive bus A, active low |
| a2b_use_reg | input | 1 | Source for bus B: 0 live A, 1 A-side register |
| b2a_use_reg | input | 1 | Source for bus A: 0 live B, 1 B-side register |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value the block drives on bus A |
| a_oe | output | 1 | Bus A driver enable |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value the block drives on bus B |
| b_oe | output | 1 | Bus B driver enable |

## Verification
At every capture edge, the assertions check that each register holds what its bus carried at the previous edge. They also check that a disabled output is zero, and that an enabled output matches either the live bus or the register, as its select demands. Some behaviours need a resolved bus with the driven value fed back, so only the bench scenarios can show them. These are the two-register load from one bus, the self-holding loop of two live directions, the isolation state with stores still working, and the asynchronous clear. The bench reads each register through the stored-data path on the opposite bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // source picked by a direction's select input
   typedef enum logic {
      SRC_LIVE = 1'b0,
      SRC_HELD = 1'b1
   } src_sel_e;

   // level at which a direction's drive enable is active
   typedef enum logic {
      EN_ACT_HIGH = 1'b0,
      EN_ACT_LOW  = 1'b1
   } en_pol_e;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int unsigned        WIDTH       = 8,
   parameter bit                 PER_BIT     = 1'b1,
   parameter logic [WIDTH-1:0]   RESET_VALUE = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_store: WIDTH must be at least 1");
   end

   if (PER_BIT) begin : g_bitwise
      // one flop per channel, identical slices
      for (genvar g = 0; g < WIDTH; g++) begin : g_bit
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q_o[g] <= RESET_VALUE[g];
            else         q_o[g] <= d_i[g];
         end
      end
   end else begin : g_vector
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o <= RESET_VALUE;
         else         q_o <= d_i;
      end
   end

   // each edge keeps the bus value seen at that edge until the next one
   assert_capture_R2_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (q_o == $past(d_i)))
      else $error("register did not hold the value captured at the previous edge");

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH           = 8,
   parameter en_pol_e     ENABLE_POLARITY = EN_ACT_HIGH
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  src_sel_e         sel_i,
   input  logic [WIDTH-1:0] live_i,
   input  logic [WIDTH-1:0] held_i,
   output logic             oe_o,
   output logic [WIDTH-1:0] out_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_lane: WIDTH must be at least 1");
   end

   logic             drive;
   logic [WIDTH-1:0] pick;

   // polarity variant chosen at elaboration
   if (ENABLE_POLARITY == EN_ACT_LOW) begin : g_pol_low
      assign drive = ~en_i;
   end else begin : g_pol_high
      assign drive = en_i;
   end

   assign oe_o = drive;

   // one two-input selector and gate per channel
   for (genvar g = 0; g < WIDTH; g++) begin : g_chan
      assign pick[g]  = (sel_i == SRC_HELD) ? held_i[g] : live_i[g];
      assign out_o[g] = drive & pick[g];
   end

   assert_idle_zero_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_o |-> (out_o == '0))
      else $error("disabled output is not zero");

   assert_live_R6_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_o && sel_i == SRC_LIVE) |-> (out_o == live_i))
      else $error("live source not passed through");

   assert_held_R6_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_o && sel_i == SRC_HELD) |-> (out_o == held_i))
      else $error("register source not passed through");

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             rst_n,
   input  logic             a2b_clk,
   input  logic             b2a_clk,
   input  logic             a2b_drive_en,
   input  logic             b2a_drive_n,
   input  logic             a2b_use_reg,
   input  logic             b2a_use_reg,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   if (WIDTH < 1) begin : g_bad_width
      $error("bus_xcvr_reg: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] held_a;
   logic [WIDTH-1:0] held_b;

   xcvr_store #(.WIDTH(WIDTH)) u_store_a (
      .clk_i  (a2b_clk),
      .rst_ni (rst_n),
      .d_i    (a_in),
      .q_o    (held_a)
   );

   xcvr_store #(.WIDTH(WIDTH)) u_store_b (
      .clk_i  (b2a_clk),
      .rst_ni (rst_n),
      .d_i    (b_in),
      .q_o    (held_b)
   );

   xcvr_lane #(.WIDTH(WIDTH), .ENABLE_POLARITY(EN_ACT_HIGH)) u_lane_to_b (
      .clk_i  (a2b_clk),
      .rst_ni (rst_n),
      .en_i   (a2b_drive_en),
      .sel_i  (src_sel_e'(a2b_use_reg)),
      .live_i (a_in),
      .held_i (held_a),
      .oe_o   (b_oe),
      .out_o  (b_out)
   );

   xcvr_lane #(.WIDTH(WIDTH), .ENABLE_POLARITY(EN_ACT_LOW)) u_lane_to_a (
      .clk_i  (b2a_clk),
      .rst_ni (rst_n),
      .en_i   (b2a_drive_n),
      .sel_i  (src_sel_e'(b2a_use_reg)),
      .live_i (b_in),
      .held_i (held_b),
      .oe_o   (a_oe),
      .out_o  (a_out)
   );

endmodule

// File: tb/test_bus_xcvr_reg.sv
`timescale 1ns/1ps
module test_bus_xcvr_reg;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ca, cb, en_ab, en_ba_n, s_ab, s_ba;
   logic [7:0] a_in, b_in, a_out, b_out;
   logic       a_oe, b_oe;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   bus_xcvr_reg i_bus_xcvr_reg (
      .rst_n(rst_n), .a2b_clk(ca), .b2a_clk(cb),
      .a2b_drive_en(en_ab), .b2a_drive_n(en_ba_n),
      .a2b_use_reg(s_ab), .b2a_use_reg(s_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic set_ctl(input logic eab, input logic eban, input logic sab, input logic sba);
      en_ab = eab; en_ba_n = eban; s_ab = sab; s_ba = sba;
      #1;
   endtask

   task automatic pulse(input logic do_a, input logic do_b);
      @(negedge clk); ca = do_a; cb = do_b;
      @(posedge clk); #0.5; ca = 1'b0; cb = 1'b0;
      #1;
   endtask

   // view both registers through the stored paths
   task automatic peek(output logic [7:0] ra, output logic [7:0] rb);
      set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
      ra = b_out; rb = a_out;
   endtask

   task automatic t_reset;
      logic [7:0] ra, rb;
      rst_n = 1'b0; ca = 0; cb = 0; a_in = 8'h00; b_in = 8'h00;
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      repeat (3) @(posedge clk);
      peek(ra, rb);
      check("R1 reset A reg", ra, 8'h00);
      check("R1 reset B reg", rb, 8'h00);
      @(negedge clk); rst_n = 1'b1; #1;
   endtask

   task automatic t_isolation;
      logic [7:0] ra, rb;
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      a_in = 8'h3C; b_in = 8'hA5; #1;
      check("R4 a_oe off", {7'd0, a_oe}, 8'h00);
      check("R4 b_oe off", {7'd0, b_oe}, 8'h00);
      check("R5 a_out zero", a_out, 8'h00);
      check("R5 b_out zero", b_out, 8'h00);
      pulse(1'b1, 1'b1);
      peek(ra, rb);
      check("R8 R2 isolation store A", ra, 8'h3C);
      check("R8 R3 isolation store B", rb, 8'hA5);
   endtask

   task automatic t_capture_any_ctl;
      logic [7:0] ra, rb;
      set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
      a_in = 8'h5A; b_in = 8'h77; #1;
      pulse(1'b1, 1'b0);
      check("R2 capture with stored select", b_out, 8'h5A);
      check("R5 B-to-A off zero", a_out, 8'h00);
      set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
      b_in = 8'h19; a_in = 8'hE4; #1;
      pulse(1'b0, 1'b1);
      check("R3 capture while B-to-A stored", a_out, 8'h19);
      peek(ra, rb);
      check("R2 A reg untouched by B clock", ra, 8'h5A);
   endtask

   task automatic t_live_a2b;
      set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
      a_in = 8'hC3; #1;
      check("R4 b_oe on", {7'd0, b_oe}, 8'h01);
      check("R6 live A to B", b_out, 8'hC3);
      check("R4 a_oe off", {7'd0, a_oe}, 8'h00);
      a_in = 8'h0F; #1;
      check("R6 live follows without clock", b_out, 8'h0F);
   endtask

   task automatic t_live_b2a;
      set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
      b_in = 8'hE1; #1;
      check("R4 a_oe on", {7'd0, a_oe}, 8'h01);
      check("R7 live B to A", a_out, 8'hE1);
      check("R5 b_out zero", b_out, 8'h00);
   endtask

   task automatic t_held_both;
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      a_in = 8'h11; b_in = 8'h22; #1;
      pulse(1'b1, 1'b1);
      set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
      a_in = 8'hFF; b_in = 8'h00; #1;
      check("R11 stored A on B", b_out, 8'h11);
      check("R11 stored B on A", a_out, 8'h22);
   endtask

   task automatic t_both_from_a;
      logic [7:0] ra, rb;
      set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
      a_in = 8'h6D; #1;
      b_in = b_out; #1;   // resolved bus B carries the driven value
      pulse(1'b1, 1'b1);
      peek(ra, rb);
      check("R10 A value in A reg", ra, 8'h6D);
      check("R10 A value in B reg", rb, 8'h6D);
   endtask

   task automatic t_both_from_b;
      logic [7:0] ra, rb;
      set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
      b_in = 8'h92; #1;
      a_in = a_out; #1;   // resolved bus A carries the driven value
      pulse(1'b1, 1'b1);
      peek(ra, rb);
      check("R10 B value in A reg", ra, 8'h92);
      check("R10 B value in B reg", rb, 8'h92);
   endtask

   task automatic t_loop;
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      a_in = 8'h47; b_in = 8'h47; #1;
      set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
      check("R9 loop holds on A", a_out, 8'h47);
      check("R9 loop holds on B", b_out, 8'h47);
      a_in = 8'h08; b_in = 8'h70; #1;
      check("R9 cross B to A", a_out, 8'h70);
      check("R9 cross A to B", b_out, 8'h08);
   endtask

   task automatic t_switch;
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      a_in = 8'hAA; #1;
      pulse(1'b1, 1'b0);
      set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
      a_in = 8'h55; #1;
      check("R6 select live", b_out, 8'h55);
      s_ab = 1'b1; #1;
      check("R6 select stored", b_out, 8'hAA);
      s_ab = 1'b0; #1;
      check("R6 select back to live", b_out, 8'h55);
   endtask

   task automatic t_async_clear;
      logic [7:0] ra, rb;
      peek(ra, rb);
      check("R1 regs loaded before clear", ra, 8'hAA);
      #1.3; rst_n = 1'b0; #1;
      peek(ra, rb);
      check("R1 async clear A", ra, 8'h00);
      check("R1 async clear B", rb, 8'h00);
      @(negedge clk); rst_n = 1'b1; #1;
   endtask

   task automatic report;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired got=1 exp=0");
         report();
         $finish;
      end
   end

   initial begin
      t_reset();
      t_isolation();
      t_capture_any_ctl();
      t_live_a2b();
      t_live_b2a();
      t_held_both();
      t_both_from_a();
      t_both_from_b();
      t_loop();
      t_switch();
      t_async_clear();
      done = 1'b1;
      report();
      $finish;
   end

endmodule